// File: doc/BRIEF.md
# Strip-Pad Coincidence Mapper

The mapper confirms a chamber trigger primitive using hits from a second detector that covers the same area. Each primitive gives a key wire-group, which runs along the radial axis, and a key half-strip, which runs across the chamber. It also carries a chamber number and a ring select. The second detector delivers, every bunch crossing, a frame of 96 strip hits: three radial rolls of 32 strips each. The block ORs every group of 8 adjacent strips into a pad bit, so each roll has four pads. From the primitive it works out the roll and pad that the primitive should land on, and it reports whether that pad fired. Downstream logic uses that result to reject ghost candidates.

The strip frames arrive several crossings after the primitive they belong to. They therefore pass through a delay line whose depth is chosen by an input before the pads are formed. Roll boundaries follow a fixed, non-uniform chamber geometry, held as fixed-point thresholds in tenths of a wire-group. On ring 2 chambers with even numbers the pad order is mirrored left to right. An optional window also accepts a hit on the pads directly next to the computed one.

Top module: `stripPadMatcher`

## Requirements
- R1: While reset is held, and at the first sample after it is released, matchOut, rollOut and padOut are all 0.
- R2: For ring 2 (ringSel=0), a key wire-group below 28 gives roll 2 (bottom), 28 to 45 gives roll 1 (middle), and 46 or more gives roll 0 (top). The limits are the fixed-point thresholds 28.0 and 45.2.
- R3: For ring 3 (ringSel=1), a key wire-group of 0 to 10 gives roll 2, 11 to 24 gives roll 1, and 25 or more gives roll 0. The limits are the thresholds 10.5 and 24.5.
- R4: The unmirrored pad index is the key half-strip divided by 40 for ring 2, or by 32 for ring 3, using integer division and clamped to 3.
- R5: For ring 2 with an even chamber number (chamberNum bit 0 = 0), the reported pad is 3 minus the unmirrored index. Odd ring 2 chambers and all ring 3 chambers are not mirrored.
- R6: The pad bit for roll r and pad p is the OR of stripFrame bits r*32+p*8 through r*32+p*8+7. Without the window, matchOut is that pad bit for the computed roll and pad.
- R7: With delaySel = D, the frame used is the one present D clock edges before the edge that samples primValid. D=0 uses the frame present at that same edge.
- R8: With windowEn=1, matchOut is also set by a fired pad at index pad-1 or pad+1 in the same roll, where that index lies within 0 to 3.
- R9: The outputs update at the clock edge that samples primValid high. After an edge that samples primValid low, matchOut is 0, and rollOut and padOut keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Active-low synchronous reset |
| primValid | input | 1 | Trigger primitive valid strobe |
| keyWg | input | 7 | Key wire-group of the primitive |
| keyHs | input | 8 | Key half-strip of the primitive |
| chamberNum | input | 6 | Chamber number; bit 0 selects even or odd |
| ringSel | input | 1 | 0 = ring 2 geometry, 1 = ring 3 geometry |
| stripFrame | input | 96 | Strip hits, roll r in bits r*32 to r*32+31 (roll 0 = top) |
| delaySel | input | 4 | Strip frame delay in clock cycles, 0 to 15 |
| windowEn | input | 1 | Also accept hits on neighbouring pads |
| matchOut | output | 1 | Registered coincidence result |
| rollOut | output | 2 | Registered roll index (0 top, 1 middle, 2 bottom) |
| padOut | output | 2 | Registered pad index after mirroring |

## Verification
The assertions check on every cycle that a low valid strobe clears the match and leaves roll and pad unchanged, that a match never follows an invalid cycle, and that the roll index is never 3. They also check a few geometry anchors: the bottom roll on ring 3 for small wire-groups, and the mirrored pad 3 for a low half-strip on even ring 2 chambers. Only the bench's scenarios can show the full threshold edges, the OR over exactly eight strips, the delay line picking the right earlier frame, and the window's treatment of the edge pads. For these the bench compares the outputs against its own frame history and geometry functions.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int NUM_ROLLS       = 3;
  localparam int STRIPS_PER_ROLL = 32;
  localparam int STRIPS_PER_PAD  = 8;
  localparam int WG_W            = 7;
  localparam int HS_W            = 8;
  localparam int CH_W            = 6;
  localparam int DLY_W           = 4;

  // Roll limits, in tenths of a wire-group
  localparam int R2_BOT_LIMIT = 280;
  localparam int R2_MID_LIMIT = 452;
  localparam int R3_BOT_LIMIT = 105;
  localparam int R3_MID_LIMIT = 245;

  // Half-strips per pad for each ring
  localparam int R2_PAD_SPAN = 40;
  localparam int R3_PAD_SPAN = 32;

  typedef enum logic [1:0] {
    ROLL_TOP = 2'd0,
    ROLL_MID = 2'd1,
    ROLL_BOT = 2'd2
  } rollIdx_t;

  typedef struct packed {
    logic capture;
    logic clearMatch;
    logic ringIs3;
    logic mirror;
    logic widen;
  } spmStrobe_t;
endpackage

// File: rtl/spmCtrl.sv
module spmCtrl
  import spm_pkg::*;
#(
  parameter int CHW = CH_W
) (
  input  logic             primValid,
  input  logic             ringSel,
  input  logic [CHW-1:0]   chamberNum,
  input  logic             windowEn,
  output spmStrobe_t       strobes
);
  logic evenChamber;

  assign evenChamber = ~chamberNum[0];

  always_comb begin
    strobes            = '0;
    strobes.capture    = primValid;
    strobes.clearMatch = ~primValid;
    strobes.ringIs3    = ringSel;
    strobes.mirror     = ~ringSel & evenChamber;
    strobes.widen      = windowEn;
  end
endmodule

// File: rtl/spmPath.sv
module spmPath
  import spm_pkg::*;
#(
  parameter int ROLLS   = NUM_ROLLS,
  parameter int SPR     = STRIPS_PER_ROLL,
  parameter int SPP     = STRIPS_PER_PAD,
  parameter int WGW     = WG_W,
  parameter int HSW     = HS_W,
  parameter int DLYW    = DLY_W,
  localparam int PADS   = SPR / SPP,
  localparam int FRAMEW = ROLLS * SPR,
  localparam int DEPTH  = (1 << DLYW) - 1,
  localparam int TW     = WGW + 4,
  localparam int PADW   = $clog2(PADS),
  localparam int ROLLW  = $clog2(ROLLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spmStrobe_t        strobes,
  input  logic [WGW-1:0]    keyWg,
  input  logic [HSW-1:0]    keyHs,
  input  logic [FRAMEW-1:0] stripFrame,
  input  logic [DLYW-1:0]   delaySel,
  output logic              matchOut,
  output logic [ROLLW-1:0]  rollOut,
  output logic [PADW-1:0]   padOut
);
  // Delay line: stage k holds the frame from k+1 edges ago
  logic [FRAMEW-1:0] stage [DEPTH];
  logic [FRAMEW-1:0] alignedFrame;

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= stripFrame;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_delay
    always_ff @(posedge clk) begin
      if (!rstN) stage[k] <= '0;
      else       stage[k] <= stage[k-1];
    end
  end

  always_comb begin
    if (delaySel == '0) alignedFrame = stripFrame;
    else                alignedFrame = stage[delaySel - DLYW'(1)];
  end

  // Pad OR over each group of adjacent strips
  logic [ROLLS*PADS-1:0] padBits;

  for (genvar r = 0; r < ROLLS; r++) begin : g_roll
    for (genvar p = 0; p < PADS; p++) begin : g_pad
      assign padBits[r*PADS + p] = |alignedFrame[r*SPR + p*SPP +: SPP];
    end
  end

  // Radial geometry: roll from fixed-point thresholds
  logic [TW-1:0]    wgTenths;
  logic [TW-1:0]    botLimit, midLimit;
  logic [ROLLW-1:0] rollCalc;

  assign wgTenths = TW'(keyWg) * TW'(10);
  assign botLimit = strobes.ringIs3 ? TW'(R3_BOT_LIMIT) : TW'(R2_BOT_LIMIT);
  assign midLimit = strobes.ringIs3 ? TW'(R3_MID_LIMIT) : TW'(R2_MID_LIMIT);

  always_comb begin
    if (wgTenths < botLimit)      rollCalc = ROLLW'(ROLL_BOT);
    else if (wgTenths < midLimit) rollCalc = ROLLW'(ROLL_MID);
    else                          rollCalc = ROLLW'(ROLL_TOP);
  end

  // Lateral geometry: pad from half-strip, clamp, mirror
  logic [HSW-1:0]  hsQuot;
  logic [PADW-1:0] padRaw, padCalc;

  assign hsQuot = strobes.ringIs3 ? (keyHs / HSW'(R3_PAD_SPAN))
                                  : (keyHs / HSW'(R2_PAD_SPAN));
  assign padRaw  = (hsQuot > HSW'(PADS - 1)) ? PADW'(PADS - 1) : hsQuot[PADW-1:0];
  assign padCalc = strobes.mirror ? (PADW'(PADS - 1) - padRaw) : padRaw;

  // Coincidence with optional neighbour window
  logic centreHit, lowHit, highHit, hitCalc;
  int   baseIdx;

  always_comb begin
    baseIdx   = int'(rollCalc) * PADS;
    centreHit = padBits[baseIdx + int'(padCalc)];
    lowHit    = 1'b0;
    highHit   = 1'b0;
    if (padCalc != '0)
      lowHit  = padBits[baseIdx + int'(padCalc) - 1];
    if (padCalc != PADW'(PADS - 1))
      highHit = padBits[baseIdx + int'(padCalc) + 1];
    hitCalc = centreHit | (strobes.widen & (lowHit | highHit));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchOut <= 1'b0;
      rollOut  <= '0;
      padOut   <= '0;
    end else if (strobes.capture) begin
      matchOut <= hitCalc;
      rollOut  <= rollCalc;
      padOut   <= padCalc;
    end else if (strobes.clearMatch) begin
      matchOut <= 1'b0;
    end
  end
endmodule

// File: rtl/stripPadMatcher.sv
module stripPadMatcher
  import spm_pkg::*;
#(
  parameter int ROLLS   = NUM_ROLLS,
  parameter int SPR     = STRIPS_PER_ROLL,
  parameter int SPP     = STRIPS_PER_PAD,
  parameter int WGW     = WG_W,
  parameter int HSW     = HS_W,
  parameter int CHW     = CH_W,
  parameter int DLYW    = DLY_W,
  localparam int FRAMEW = ROLLS * SPR,
  localparam int PADW   = $clog2(SPR / SPP),
  localparam int ROLLW  = $clog2(ROLLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              primValid,
  input  logic [WGW-1:0]    keyWg,
  input  logic [HSW-1:0]    keyHs,
  input  logic [CHW-1:0]    chamberNum,
  input  logic              ringSel,
  input  logic [FRAMEW-1:0] stripFrame,
  input  logic [DLYW-1:0]   delaySel,
  input  logic              windowEn,
  output logic              matchOut,
  output logic [ROLLW-1:0]  rollOut,
  output logic [PADW-1:0]   padOut
);
  spmStrobe_t strobes;

  spmCtrl #(.CHW(CHW)) u_ctrl (
    .primValid (primValid),
    .ringSel   (ringSel),
    .chamberNum(chamberNum),
    .windowEn  (windowEn),
    .strobes   (strobes)
  );

  spmPath #(
    .ROLLS(ROLLS), .SPR(SPR), .SPP(SPP),
    .WGW(WGW), .HSW(HSW), .DLYW(DLYW)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .keyWg     (keyWg),
    .keyHs     (keyHs),
    .stripFrame(stripFrame),
    .delaySel  (delaySel),
    .matchOut  (matchOut),
    .rollOut   (rollOut),
    .padOut    (padOut)
  );
endmodule

// File: rtl/spmChecker.sv
module spmChecker (
  input logic       clk,
  input logic       rstN,
  input logic       primValid,
  input logic [6:0] keyWg,
  input logic [7:0] keyHs,
  input logic [5:0] chamberNum,
  input logic       ringSel,
  input logic       matchOut,
  input logic [1:0] rollOut,
  input logic [1:0] padOut
);
  // R9
  invalid_clears_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !primValid |=> !matchOut);

  // R9
  invalid_holds_geometry_chk: assert property (@(posedge clk) disable iff (!rstN)
    !primValid |=> ($stable(rollOut) && $stable(padOut)));

  // R2
  roll_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollOut != 2'd3);

  // R3
  ring3_bottom_roll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && ringSel && keyWg < 7'd11) |=> rollOut == 2'd2);

  // R5
  even_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && !ringSel && !chamberNum[0] && keyHs < 8'd40) |=> padOut == 2'd3);

  // R4
  ring3_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && ringSel && keyHs >= 8'd96) |=> padOut == 2'd3);
endmodule

bind stripPadMatcher spmChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .primValid (primValid),
  .keyWg     (keyWg),
  .keyHs     (keyHs),
  .chamberNum(chamberNum),
  .ringSel   (ringSel),
  .matchOut  (matchOut),
  .rollOut   (rollOut),
  .padOut    (padOut)
);

// File: tb/sim_stripPadMatcher.sv
`timescale 1ns/1ps
module sim_stripPadMatcher;
  logic        clk = 1'b0;
  logic        rstN;
  logic        primValid;
  logic [6:0]  keyWg;
  logic [7:0]  keyHs;
  logic [5:0]  chamberNum;
  logic        ringSel;
  logic [95:0] stripFrame;
  logic [3:0]  delaySel;
  logic        windowEn;
  logic        matchOut;
  logic [1:0]  rollOut;
  logic [1:0]  padOut;

  int checks = 0;
  int errors = 0;
  logic [95:0] hist [16];
  logic [1:0]  heldRoll, heldPad;

  always #10 clk = ~clk;

  stripPadMatcher u0 (
    .clk(clk), .rstN(rstN), .primValid(primValid), .keyWg(keyWg), .keyHs(keyHs),
    .chamberNum(chamberNum), .ringSel(ringSel), .stripFrame(stripFrame),
    .delaySel(delaySel), .windowEn(windowEn), .matchOut(matchOut),
    .rollOut(rollOut), .padOut(padOut)
  );

  function automatic logic [1:0] expRoll(logic ring3, logic [6:0] wg);
    if (!ring3) return (wg < 28) ? 2'd2 : (wg <= 45) ? 2'd1 : 2'd0;
    return (wg <= 10) ? 2'd2 : (wg <= 24) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [1:0] expPad(logic ring3, logic [5:0] ch, logic [7:0] hs);
    int q;
    q = ring3 ? hs / 32 : hs / 40;
    if (q > 3) q = 3;
    if (!ring3 && !ch[0]) q = 3 - q;
    return 2'(q);
  endfunction

  function automatic logic padBit(logic [95:0] f, int r, int p);
    return |f[r*32 + p*8 +: 8];
  endfunction

  function automatic logic expMatch(logic [95:0] f, logic [1:0] r, logic [1:0] p, logic win);
    logic m;
    m = padBit(f, r, p);
    if (win && p > 0) m = m | padBit(f, r, p - 1);
    if (win && p < 3) m = m | padBit(f, r, p + 1);
    return m;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: compute expectation, take edge, compare, record frame
  task automatic step(string rollTag);
    logic        v;
    logic [1:0]  eR, eP;
    logic        eM;
    logic [95:0] sel;
    v   = primValid;
    sel = (delaySel == 0) ? stripFrame : hist[delaySel - 1];
    eR  = expRoll(ringSel, keyWg);
    eP  = expPad(ringSel, chamberNum, keyHs);
    eM  = expMatch(sel, eR, eP, windowEn);
    @(posedge clk);
    #5;
    if (v) begin
      chk(rollTag, int'(rollOut), int'(eR));
      chk("R4 pad (R5 mirror)", int'(padOut), int'(eP));
      chk("R6 match (R7 delay, R8 window)", int'(matchOut), int'(eM));
      heldRoll = eR;
      heldPad  = eP;
    end else begin
      chk("R9 match cleared", int'(matchOut), 0);
      chk("R9 roll held", int'(rollOut), int'(heldRoll));
      chk("R9 pad held", int'(padOut), int'(heldPad));
    end
    for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = stripFrame;
  endtask

  task automatic setPrim(logic v, logic ring3, logic [6:0] wg, logic [7:0] hs, logic [5:0] ch);
    primValid = v; ringSel = ring3; keyWg = wg; keyHs = hs; chamberNum = ch;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    rstN = 1'b0; stripFrame = '1; delaySel = 0; windowEn = 1'b1;
    setPrim(1'b1, 1'b0, 7'd60, 8'd100, 6'd3);
    for (int k = 0; k < 16; k++) hist[k] = '0;
    heldRoll = 0; heldPad = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset match", int'(matchOut), 0);
    chk("R1 reset roll", int'(rollOut), 0);
    chk("R1 reset pad", int'(padOut), 0);
    stripFrame = '0; primValid = 1'b0; windowEn = 1'b0;
    rstN = 1'b1;
    @(posedge clk); #5;
    chk("R1 after release match", int'(matchOut), 0);
    chk("R1 after release roll", int'(rollOut), 0);
    chk("R1 after release pad", int'(padOut), 0);

    // R2 threshold edges on ring 2
    setPrim(1'b1, 1'b0, 7'd27, 8'd0, 6'd1); step("R2 roll");
    chk("R2 wg27 bottom", int'(rollOut), 2);
    setPrim(1'b1, 1'b0, 7'd28, 8'd0, 6'd1); step("R2 roll");
    chk("R2 wg28 middle", int'(rollOut), 1);
    setPrim(1'b1, 1'b0, 7'd45, 8'd0, 6'd1); step("R2 roll");
    chk("R2 wg45 middle", int'(rollOut), 1);
    setPrim(1'b1, 1'b0, 7'd46, 8'd0, 6'd1); step("R2 roll");
    chk("R2 wg46 top", int'(rollOut), 0);
    // R3 threshold edges on ring 3
    setPrim(1'b1, 1'b1, 7'd10, 8'd0, 6'd1); step("R3 roll");
    chk("R3 wg10 bottom", int'(rollOut), 2);
    setPrim(1'b1, 1'b1, 7'd11, 8'd0, 6'd1); step("R3 roll");
    chk("R3 wg11 middle", int'(rollOut), 1);
    setPrim(1'b1, 1'b1, 7'd24, 8'd0, 6'd1); step("R3 roll");
    chk("R3 wg24 middle", int'(rollOut), 1);
    setPrim(1'b1, 1'b1, 7'd25, 8'd0, 6'd1); step("R3 roll");
    chk("R3 wg25 top", int'(rollOut), 0);
    // R4 pad division and clamp
    setPrim(1'b1, 1'b0, 7'd60, 8'd159, 6'd1); step("R2 roll");
    chk("R4 ring2 hs159", int'(padOut), 3);
    setPrim(1'b1, 1'b1, 7'd30, 8'd200, 6'd1); step("R3 roll");
    chk("R4 ring3 clamp", int'(padOut), 3);
    setPrim(1'b1, 1'b1, 7'd30, 8'd63, 6'd2); step("R3 roll");
    chk("R4 ring3 hs63 no mirror", int'(padOut), 1);
    // R5 mirror on even ring 2 chamber
    setPrim(1'b1, 1'b0, 7'd60, 8'd45, 6'd4); step("R2 roll");
    chk("R5 even mirrored", int'(padOut), 2);
    setPrim(1'b1, 1'b0, 7'd60, 8'd45, 6'd5); step("R2 roll");
    chk("R5 odd unmirrored", int'(padOut), 1);

    // R6 single strip at top edge of pad 1 in roll 1
    stripFrame = '0; stripFrame[32 + 15] = 1'b1;
    setPrim(1'b1, 1'b0, 7'd30, 8'd50, 6'd1); step("R2 roll");
    chk("R6 strip 15 of roll1 hits pad1", int'(matchOut), 1);
    setPrim(1'b1, 1'b0, 7'd30, 8'd90, 6'd1); step("R2 roll");
    chk("R6 pad2 not hit", int'(matchOut), 0);
    // R8 window widens to neighbour
    windowEn = 1'b1; step("R2 roll");
    chk("R8 window pad1 next to pad2", int'(matchOut), 1);
    stripFrame = '0; stripFrame[32 + 0] = 1'b1;
    setPrim(1'b1, 1'b0, 7'd30, 8'd159, 6'd1); step("R2 roll");
    chk("R8 pad3 window does not reach pad0", int'(matchOut), 0);
    windowEn = 1'b0;

    // R7 delayed frame: hit 5 edges before the valid edge
    delaySel = 4'd5;
    stripFrame = '0; stripFrame[3] = 1'b1; primValid = 1'b0; step("R9");
    stripFrame = '0;
    repeat (4) step("R9");
    setPrim(1'b1, 1'b0, 7'd60, 8'd0, 6'd1); step("R2 roll");
    chk("R7 delay 5 finds hit", int'(matchOut), 1);
    delaySel = 4'd4; step("R2 roll");
    chk("R7 delay 4 misses", int'(matchOut), 0);
    delaySel = 4'd0;

    // R9 invalid cycle clears match and holds geometry
    stripFrame = '1;
    setPrim(1'b1, 1'b1, 7'd20, 8'd70, 6'd1); step("R3 roll");
    setPrim(1'b0, 1'b0, 7'd100, 8'd0, 6'd2); step("R9");
    chk("R9 roll held after invalid", int'(rollOut), 1);
    chk("R9 match cleared", int'(matchOut), 0);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      primValid  = ($urandom % 4) != 0;
      ringSel    = 1'($urandom % 2);
      keyWg      = ringSel ? 7'($urandom % 40) : 7'($urandom % 70);
      keyHs      = ringSel ? 8'($urandom % 140) : 8'($urandom % 170);
      chamberNum = 6'($urandom);
      windowEn   = ($urandom % 3) == 0;
      delaySel   = 4'($urandom);
      stripFrame = {$urandom & $urandom & $urandom,
                    $urandom & $urandom & $urandom,
                    $urandom & $urandom & $urandom};
      step(ringSel ? "R3 roll" : "R2 roll");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule